// File: doc/BRIEF.md
# Flash Protection and Chip-Erase Gate

This block decides whether a serial flash controller may change its storage array. It watches command bytes that arrive on a valid/ready byte stream while an active-low frame select is held low. When the frame select rises, it decodes the bytes of that frame. It acts only when the frame carried exactly four bytes. The recognised commands are:

- chip erase
- sector erase
- page program
- software protect on and off
- error clear

Protection is the OR of two sources. One is a software enable set by command. The other is a hardware write-protect input, latched into the block. A per-sector mask picks the sectors that protection covers. The mask is held in a plain register and loaded from a parallel input.

When an operation is granted, the block sends a one-cycle grant pulse to the array sequencer, carrying the operation kind and sector. It then holds busy for a programmable number of cycles. A refused operation starts nothing and sets a sticky error flag. The hardware write-protect input is sampled only while idle, so a change during an erase takes effect after that erase ends.

The byte stream never applies back-pressure. `cmd_ready` is high at all times after reset, so every byte offered with `cmd_valid` is taken. Bytes taken while busy are thrown away. `NSECT` must be a power of two.

Top module: `flash_gate`

## Requirements
- R1: A grant of kind 2 (chip erase) is issued only for the byte sequence C7h, 94h, 80h, 9Ah in that order within one frame; any other order grants nothing.
- R2: A frame is decoded only at the rising edge of `frame_n` and only if exactly four bytes were accepted in it; frames of three or five bytes have no effect.
- R3: Frame 6Bh,19h,E4h,01h sets the software enable and frame 6Bh,19h,E4h,00h clears it; `status[1]` shows protection enabled.
- R4: Protection is enabled (`status[1]`=1) when the software enable is set or the latched write-protect (`status[2]`) is 1.
- R5: The latched write-protect follows `wp_in` one cycle later while idle and is frozen while busy, so an assertion during an erase is applied after it completes.
- R6: Frame 2Ch,s,x,x requests a page program (kind 0) and 5Eh,s,x,x a sector erase (kind 1). The sector is the low log2(NSECT) bits of s. When allowed, `go_valid` pulses for one cycle, one cycle after the frame ends, with `go_kind` and `go_sector`.
- R7: A program or sector erase to a sector whose mask bit is 1 while protection is enabled is dropped: no grant, no busy, and `status[3]` (error) is set.
- R8: Chip erase is refused and sets the error flag when protection is enabled and any mask bit is 1; otherwise it is granted.
- R9: The error flag is sticky and is cleared only by frame 6Bh,19h,E4h,C3h.
- R10: After a grant, `busy` and `status[0]` stay high for `erase_cycles` cycles, or for one cycle when `erase_cycles` is 0.
- R11: Frames that end while busy, and bytes accepted while busy, have no effect.
- R12: When `mask_load` is high and the block is idle, the mask takes `mask_in`; it resets to all ones.
- R13: After reset, `status` is 0, `busy` and `go_valid` are 0, the software enable is clear, and `cmd_ready` is 1 from the first clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low command frame select |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Command byte ready (high after reset) |
| cmd_data | input | 8 | Command byte |
| wp_in | input | 1 | Hardware write-protect request |
| mask_load | input | 1 | Load strobe for the sector mask |
| mask_in | input | NSECT | New sector mask |
| erase_cycles | input | CW | Busy duration in cycles |
| go_valid | output | 1 | One-cycle grant pulse |
| go_kind | output | 2 | 0 program, 1 sector erase, 2 chip erase |
| go_sector | output | SW | Granted sector |
| busy | output | 1 | Self-timed operation in progress |
| status | output | 4 | {error, wp latched, protection on, busy} |

## Verification
The hardest case to produce is a write-protect rise that lands in the middle of an erase. It must leave the latched bit unchanged until busy falls, and only then appear. The stimulus sets a long erase count, starts a sector erase, and raises `wp_in` while busy is still high. It checks that `status[2]` is still 0 before the erase ends and 1 just after.

The bench also sends a whole protect-on frame inside a long busy window. It confirms the frame has no effect once the block is idle again.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_CHIP, CMD_PROG, CMD_SERASE, CMD_SWON, CMD_SWOFF, CMD_CLR
  } cmd_e;

  typedef enum logic [1:0] {
    K_PROG   = 2'd0,
    K_SERASE = 2'd1,
    K_CHIP   = 2'd2
  } kind_e;

  localparam logic [31:0] SEQ_CHIP   = 32'hC794_809A;
  localparam logic [23:0] SEQ_CTRL   = 24'h6B_19E4;
  localparam logic [7:0]  OP_PROG    = 8'h2C;
  localparam logic [7:0]  OP_SERASE  = 8'h5E;
  localparam logic [7:0]  ARG_ON     = 8'h01;
  localparam logic [7:0]  ARG_OFF    = 8'h00;
  localparam logic [7:0]  ARG_CLR    = 8'hC3;
  localparam int          FRAME_LEN  = 4;
endpackage

// File: rtl/fg_frame_rx.sv
module fg_frame_rx
  import flash_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_data,
  input  logic        busy,
  output logic        cmd_ready,
  output logic        frame_end,
  output logic [31:0] bytes,
  output logic [2:0]  nbytes
);
  logic frame_q;

  // rising edge of the frame select, seen on the cycle it arrives
  assign frame_end = frame_n & ~frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q   <= 1'b1;
      cmd_ready <= 1'b0;
      nbytes    <= '0;
      bytes     <= '0;
    end else begin
      frame_q   <= frame_n;
      cmd_ready <= 1'b1;
      if (frame_n) begin
        nbytes <= '0;
      end else if (cmd_valid && cmd_ready && !busy) begin
        // count saturates one past a full frame so oversize frames are seen
        if (nbytes <= 3'(FRAME_LEN)) nbytes <= nbytes + 3'd1;
        if (nbytes < 3'(FRAME_LEN))  bytes  <= {bytes[23:0], cmd_data};
      end
    end
  end
endmodule

// File: rtl/fg_decode.sv
module fg_decode
  import flash_gate_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic [31:0]   bytes,
  input  logic [2:0]    nbytes,
  output cmd_e          cmd,
  output logic [SW-1:0] sector
);
  logic [7:0] b0, b1, b3;

  assign b0     = bytes[31:24];
  assign b1     = bytes[23:16];
  assign b3     = bytes[7:0];
  assign sector = b1[SW-1:0];

  always_comb begin
    cmd = CMD_NONE;
    if (nbytes == 3'(FRAME_LEN)) begin
      if (bytes == SEQ_CHIP)            cmd = CMD_CHIP;
      else if (b0 == OP_PROG)           cmd = CMD_PROG;
      else if (b0 == OP_SERASE)         cmd = CMD_SERASE;
      else if (bytes[31:8] == SEQ_CTRL) begin
        case (b3)
          ARG_ON:  cmd = CMD_SWON;
          ARG_OFF: cmd = CMD_SWOFF;
          ARG_CLR: cmd = CMD_CLR;
          default: cmd = CMD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fg_prot.sv
module fg_prot
  import flash_gate_pkg::*;
#(
  parameter int NSECT = 8,
  parameter int SW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  cmd_e             cmd,
  input  logic [SW-1:0]    sector,
  input  logic             wp_in,
  input  logic             busy,
  input  logic             mask_load,
  input  logic [NSECT-1:0] mask_in,
  output logic             grant,
  output logic             go_valid,
  output logic [1:0]       go_kind,
  output logic [SW-1:0]    go_sector,
  output logic             sw_en,
  output logic             wp_lat,
  output logic             err,
  output logic             prot_on,
  output logic [NSECT-1:0] mask_q
);
  logic  deny;
  kind_e kind;

  assign prot_on = sw_en | wp_lat;

  always_comb begin
    grant = 1'b0;
    deny  = 1'b0;
    kind  = K_PROG;
    if (start) begin
      case (cmd)
        CMD_CHIP: begin
          kind = K_CHIP;
          if (prot_on && |mask_q) deny = 1'b1;
          else                    grant = 1'b1;
        end
        CMD_PROG, CMD_SERASE: begin
          kind = (cmd == CMD_PROG) ? K_PROG : K_SERASE;
          if (prot_on && mask_q[sector]) deny = 1'b1;
          else                           grant = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en     <= 1'b0;
      wp_lat    <= 1'b0;
      err       <= 1'b0;
      mask_q    <= '1;
      go_valid  <= 1'b0;
      go_kind   <= '0;
      go_sector <= '0;
    end else begin
      go_valid <= grant;
      if (grant) begin
        go_kind   <= kind;
        go_sector <= (kind == K_CHIP) ? '0 : sector;
      end
      // hardware protect is sampled only between operations
      if (!busy) wp_lat <= wp_in;
      if (mask_load && !busy) mask_q <= mask_in;
      if (start && cmd == CMD_SWON)  sw_en <= 1'b1;
      if (start && cmd == CMD_SWOFF) sw_en <= 1'b0;
      if (deny)                      err <= 1'b1;
      else if (start && cmd == CMD_CLR) err <= 1'b0;
    end
  end
endmodule

// File: rtl/fg_busy_timer.sv
module fg_busy_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cycles,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= (cycles == '0) ? CW'(1) : cycles;
    end else if (busy) begin
      if (cnt <= CW'(1)) busy <= 1'b0;
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/flash_gate.sv
module flash_gate
  import flash_gate_pkg::*;
#(
  parameter int NSECT = 8,
  parameter int CW    = 16,
  localparam int SW   = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_data,
  input  logic             wp_in,
  input  logic             mask_load,
  input  logic [NSECT-1:0] mask_in,
  input  logic [CW-1:0]    erase_cycles,
  output logic             go_valid,
  output logic [1:0]       go_kind,
  output logic [SW-1:0]    go_sector,
  output logic             busy,
  output logic [3:0]       status
);
  logic             frame_end, start, grant;
  logic [31:0]      bytes;
  logic [2:0]       nbytes;
  cmd_e             cmd;
  logic [SW-1:0]    sector;
  logic             sw_en, wp_lat, err, prot_on;
  logic [NSECT-1:0] mask_q;

  assign start  = frame_end & ~busy;
  assign status = {err, wp_lat, prot_on, busy};

  fg_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .busy(busy), .cmd_ready(cmd_ready),
    .frame_end(frame_end), .bytes(bytes), .nbytes(nbytes)
  );

  fg_decode #(.SW(SW)) u_dec (
    .bytes(bytes), .nbytes(nbytes), .cmd(cmd), .sector(sector)
  );

  fg_prot #(.NSECT(NSECT), .SW(SW)) u_prot (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .sector(sector),
    .wp_in(wp_in), .busy(busy), .mask_load(mask_load), .mask_in(mask_in),
    .grant(grant), .go_valid(go_valid), .go_kind(go_kind),
    .go_sector(go_sector), .sw_en(sw_en), .wp_lat(wp_lat), .err(err),
    .prot_on(prot_on), .mask_q(mask_q)
  );

  fg_busy_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(grant), .cycles(erase_cycles),
    .busy(busy)
  );
endmodule

// File: rtl/flash_gate_chk.sv
module flash_gate_chk #(
  parameter int NSECT = 8,
  parameter int SW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_valid,
  input logic [1:0]       go_kind,
  input logic [SW-1:0]    go_sector,
  input logic             busy,
  input logic [3:0]       status,
  input logic [NSECT-1:0] mask_q
);
  logic [NSECT-1:0] sel;
  assign sel = NSECT'(1) << go_sector;

  p_go_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go_valid |-> busy);

  p_busy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !go_valid);

  p_wp_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(status[2]));

  p_sector_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_valid && go_kind != 2'd2) |->
      !($past(status[1]) && (($past(mask_q) & sel) != '0)));

  p_chip_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_valid && go_kind == 2'd2) |->
      (!$past(status[1]) || $past(mask_q) == '0));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go_valid |=> !go_valid);
endmodule

bind flash_gate flash_gate_chk #(.NSECT(NSECT), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_valid(go_valid), .go_kind(go_kind),
  .go_sector(go_sector), .busy(busy), .status(status), .mask_q(mask_q)
);

// File: tb/sim_flash_gate.sv
`timescale 1ns/1ps
module sim_flash_gate;
  localparam int NSECT = 8;
  localparam int CW    = 16;
  localparam int SW    = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_n = 1'b1;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [7:0]       cmd_data = '0;
  logic             wp_in = 1'b0;
  logic             mask_load = 1'b0;
  logic [NSECT-1:0] mask_in = '0;
  logic [CW-1:0]    erase_cycles = 16'd4;
  logic             go_valid;
  logic [1:0]       go_kind;
  logic [SW-1:0]    go_sector;
  logic             busy;
  logic [3:0]       status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  flash_gate #(.NSECT(NSECT), .CW(CW)) u0 (.*);

  // {bytes, count, expect grant, kind, sector}
  localparam int VN = 7;
  localparam logic [40:0] VEC [VN] = '{
    {32'hC794_809A, 3'd4, 1'b1, 2'd2, 3'd0},  // R1 chip erase
    {32'hC794_9A80, 3'd4, 1'b0, 2'd0, 3'd0},  // R1 wrong order
    {32'hC794_809A, 3'd3, 1'b0, 2'd0, 3'd0},  // R2 short frame
    {32'hC794_809A, 3'd5, 1'b0, 2'd0, 3'd0},  // R2 long frame
    {32'h2C03_0000, 3'd4, 1'b1, 2'd0, 3'd3},  // R6 program
    {32'h5E05_FFFF, 3'd4, 1'b1, 2'd1, 3'd5},  // R6 sector erase
    {32'h5E0B_0000, 3'd4, 1'b1, 2'd1, 3'd3}   // R6 sector wraps
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input int n);
    @(negedge clk);
    frame_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      cmd_valid = 1'b1;
      cmd_data  = (i < 4) ? w[31-8*i -: 8] : 8'h00;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    frame_n   = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle_wait();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_mask(input logic [NSECT-1:0] m);
    @(negedge clk);
    mask_in = m; mask_load = 1'b1;
    @(negedge clk);
    mask_load = 1'b0;
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 status", 32'(status), 0);
    chk("R13 busy", 32'(busy), 0);
    chk("R13 go", 32'(go_valid), 0);
    chk("R13 ready", 32'(cmd_ready), 1);

    for (int v = 0; v < VN; v++) begin
      send(VEC[v][40:9], int'(VEC[v][8:6]));
      chk(v < 2 ? "R1 grant" : (v < 4 ? "R2 grant" : "R6 grant"),
          32'(go_valid), 32'(VEC[v][5]));
      if (VEC[v][5]) begin
        chk("R6 kind", 32'(go_kind), 32'(VEC[v][4:3]));
        if (VEC[v][4:3] != 2'd2) chk("R6 sector", 32'(go_sector), 32'(VEC[v][2:0]));
      end
      idle_wait();
    end

    // R10 busy length
    send(32'h2C01_0000, 4);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk("R10 busy cycles", cnt, 4);
    erase_cycles = 16'd0;
    send(32'h2C01_0000, 4);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk("R10 zero count", cnt, 1);
    erase_cycles = 16'd4;

    // R3 software enable
    send(32'h6B19_E401, 4);
    chk("R3 prot on", 32'(status[1]), 1);
    // R7 protected target dropped (mask reset to all ones, R12)
    send(32'h2C02_0000, 4);
    chk("R7 no grant", 32'(go_valid), 0);
    chk("R7 no busy", 32'(busy), 0);
    chk("R7 error", 32'(status[3]), 1);
    send(32'h6B19_E400, 4);
    chk("R3 prot off", 32'(status[1]), 0);
    chk("R9 sticky", 32'(status[3]), 1);
    send(32'h6B19_E4C3, 4);
    chk("R9 cleared", 32'(status[3]), 0);

    // R12 mask load then selective protection
    load_mask(8'h0F);
    send(32'h6B19_E401, 4);
    send(32'h2C06_0000, 4);
    chk("R12 open sector", 32'(go_valid), 1);
    idle_wait();
    send(32'h2C01_0000, 4);
    chk("R12 guarded sector", 32'(go_valid), 0);
    // R8 chip erase refused with protection and nonzero mask
    send(32'hC794_809A, 4);
    chk("R8 refused", 32'(go_valid), 0);
    chk("R8 error", 32'(status[3]), 1);
    send(32'h6B19_E4C3, 4);
    load_mask(8'h00);
    send(32'hC794_809A, 4);
    chk("R8 empty mask grant", 32'(go_valid), 1);
    idle_wait();

    // R4 hardware protect
    send(32'h6B19_E400, 4);
    load_mask(8'hFF);
    wp_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 wp latched", 32'(status[2]), 1);
    chk("R4 prot on", 32'(status[1]), 1);
    send(32'h2C00_0000, 4);
    chk("R4 denied", 32'(go_valid), 0);
    send(32'h6B19_E4C3, 4);
    wp_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 wp released", 32'(status[1]), 0);

    // R11 frame inside busy window
    erase_cycles = 16'd20;
    send(32'h5E04_0000, 4);
    send(32'h6B19_E401, 4);
    chk("R11 still busy", 32'(busy), 1);
    idle_wait();
    chk("R11 ignored", 32'(status[1]), 0);

    // R5 deferred hardware protect
    send(32'h5E04_0000, 4);
    @(negedge clk);
    wp_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 busy", 32'(busy), 1);
    chk("R5 deferred", 32'(status[2]), 0);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R5 applied", 32'(status[2]), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule